// File: doc/BRIEF.md
# Single-Accumulator Processor Core with Interrupt Check

This block is a small processor built around one accumulator register. It runs a fetch-execute loop against a synchronous, word-addressed memory port. Each 16-bit instruction word has a 4-bit operation code in its upper bits and a 12-bit absolute operand address in its lower bits. The core can load the accumulator from memory, add a memory word to it, and write it back to memory. It can also halt, and it can return from an interrupt handler.

Every instruction passes through five states: fetch, decode, operand read, execute and interrupt check. Memory reads take one cycle, so data requested in one state is used in the next. In the interrupt-check state an enabled, pending request redirects the core. It saves the address of the next instruction, disables further interrupts, pulses the acknowledge output and continues at a fixed handler address. The return operation restores the saved address and re-enables interrupts. The accumulator is not saved, so a handler that changes it leaves the new value in place for the interrupted program.

Top module: `acc_core`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the core fetches from START_PC (default 0x300) with read strobe high, write strobe low and acknowledge low. Reset clears the accumulator, so a store executed first writes 0.
- R2: A fetch reads the word at the program counter, and the counter then advances by one. With five cycles per instruction, the operand read of the first instruction appears 2 cycles after reset falls, and the fetch of the next word appears 5 cycles after reset falls.
- R3: Operation code 0x1 (bits 15:12) loads the accumulator from the word at the address in bits 11:0.
- R4: Operation code 0x5 adds the addressed word to the accumulator, modulo 2^16.
- R5: Operation code 0x2 writes the accumulator to the addressed word, with exactly one write strobe. No other operation writes memory.
- R6: Operation code 0x0 halts the core: no later instruction is executed and no later write occurs.
- R7: Any operation code other than 0x0, 0x1, 0x2, 0x5 and 0xF leaves the accumulator and memory unchanged.
- R8: After reset, interrupts are disabled, and a request held high produces no acknowledge.
- R9: An enabled request seen in the interrupt-check state gives a one-cycle acknowledge pulse. During that pulse the core fetches from HANDLER_PC (default 0x010), and interrupts are now disabled.
- R10: A request raised while interrupts are disabled, including inside a handler, is not taken.
- R11: Operation code 0xF loads the program counter from the saved return address and re-enables interrupts. After reset, the saved address is START_PC+1. Execution resumes at the instruction that follows the interrupted one.
- R12: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | ADDR_W | Word address for the read or write |
| memRdEn | output | 1 | Read strobe; data returns on the next cycle |
| memWrEn | output | 1 | Write strobe |
| memWrData | output | 4+ADDR_W | Data to write (the accumulator) |
| memRdData | input | 4+ADDR_W | Read data, one cycle after the strobe |
| irqReq | input | 1 | Level interrupt request |
| irqAck | output | 1 | One-cycle acknowledge of a taken request |

## Verification
The bench builds the core with its defaults: a 12-bit address, a start address of 0x300 and a handler at 0x010. With these values the 4096-word bench memory covers the whole address space. The load-add-store program and its operands sit at their natural addresses, and the handler sits low in memory, clear of them. The arithmetic vectors include carries out of bit 15 and sign-bit crossings. The interrupt sequence includes a request raised inside the handler, a return, and a second request taken after interrupts are re-enabled.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_HALT  = 4'h0;
  localparam logic [OPC_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'h5;
  localparam logic [OPC_W-1:0] OP_RETI  = 4'hF;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_OPREAD,
    ST_EXEC,
    ST_ICHECK,
    ST_HALT
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic irLoad;
    logic pcInc;
    logic addrOperand;
    logic memRd;
    logic memWr;
    logic accLoad;
    logic accAdd;
    logic pcFromRet;
    logic retSave;
    logic pcToHandler;
  } ctrl_t;

endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_core_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             irqReq,
  output ctrl_t            ctrl,
  output logic             irqAck,
  output logic             intEn
);

  state_e state, nxtState;
  logic isLoad, isAdd, isStore, isReti, isHalt, takeIrq;

  assign isLoad  = (opcode == OP_LOAD);
  assign isAdd   = (opcode == OP_ADD);
  assign isStore = (opcode == OP_STORE);
  assign isReti  = (opcode == OP_RETI);
  assign isHalt  = (opcode == OP_HALT);

  assign takeIrq = (state == ST_ICHECK) && irqReq && intEn;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FETCH;
      intEn  <= 1'b0;
      irqAck <= 1'b0;
    end else begin
      state  <= nxtState;
      irqAck <= takeIrq;
      if (takeIrq)
        intEn <= 1'b0;
      else if (state == ST_EXEC && isReti)
        intEn <= 1'b1;
    end
  end

  always_comb begin
    ctrl     = '0;
    nxtState = state;
    case (state)
      ST_FETCH: begin
        ctrl.memRd = 1'b1;
        nxtState   = ST_DECODE;
      end
      ST_DECODE: begin
        ctrl.irLoad = 1'b1;
        ctrl.pcInc  = 1'b1;
        nxtState    = ST_OPREAD;
      end
      ST_OPREAD: begin
        ctrl.addrOperand = 1'b1;
        ctrl.memRd       = isLoad || isAdd;
        nxtState         = ST_EXEC;
      end
      ST_EXEC: begin
        ctrl.accLoad     = isLoad;
        ctrl.accAdd      = isAdd;
        ctrl.memWr       = isStore;
        ctrl.addrOperand = isStore;
        ctrl.pcFromRet   = isReti;
        nxtState         = isHalt ? ST_HALT : ST_ICHECK;
      end
      ST_ICHECK: begin
        ctrl.retSave     = takeIrq;
        ctrl.pcToHandler = takeIrq;
        nxtState         = ST_FETCH;
      end
      ST_HALT: nxtState = ST_HALT;
      default: nxtState = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_core_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] START_PC   = 'h300,
  parameter logic [ADDR_W-1:0] HANDLER_PC = 'h010,
  localparam int               DATA_W     = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  output logic [OPC_W-1:0]  opcode
);

  logic [ADDR_W-1:0] pc, retPc;
  logic [DATA_W-1:0] ir, acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= START_PC;
      retPc <= START_PC + ADDR_W'(1);
      ir    <= '0;
      acc   <= '0;
    end else begin
      if (ctrl.irLoad)
        ir <= memRdData;
      if (ctrl.pcToHandler)
        pc <= HANDLER_PC;
      else if (ctrl.pcFromRet)
        pc <= retPc;
      else if (ctrl.pcInc)
        pc <= pc + ADDR_W'(1);
      if (ctrl.retSave)
        retPc <= pc;
      if (ctrl.accLoad)
        acc <= memRdData;
      else if (ctrl.accAdd)
        acc <= acc + memRdData;
    end
  end

  assign opcode    = ir[DATA_W-1 -: OPC_W];
  assign memAddr   = ctrl.addrOperand ? ir[ADDR_W-1:0] : pc;
  assign memRdEn   = ctrl.memRd;
  assign memWrEn   = ctrl.memWr;
  assign memWrData = acc;

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] START_PC   = 'h300,
  parameter logic [ADDR_W-1:0] HANDLER_PC = 'h010,
  localparam int               DATA_W     = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              irqReq,
  output logic              irqAck
);

  ctrl_t            ctrl;
  logic [OPC_W-1:0] opcode;
  logic             intEn;

  acc_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .irqReq (irqReq),
    .ctrl   (ctrl),
    .irqAck (irqAck),
    .intEn  (intEn)
  );

  acc_datapath #(
    .ADDR_W     (ADDR_W),
    .START_PC   (START_PC),
    .HANDLER_PC (HANDLER_PC)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn),
    .memWrData (memWrData),
    .opcode    (opcode)
  );

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] START_PC   = 'h300,
  parameter logic [ADDR_W-1:0] HANDLER_PC = 'h010
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdEn,
  input logic              memWrEn,
  input logic              irqAck,
  input logic              intEn
);

  // R1
  reset_fetch_chk: assert property (@(posedge clk)
    rst |=> (memRdEn && !memWrEn && memAddr == START_PC && !irqAck));

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(memRdEn && memWrEn));

  // R9
  ack_vector_chk: assert property (@(posedge clk) disable iff (rst)
    irqAck |-> (memRdEn && memAddr == HANDLER_PC && !intEn));

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irqAck |=> !irqAck);

  // R10
  no_nest_chk: assert property (@(posedge clk) disable iff (rst)
    !intEn |=> !irqAck);

endmodule

bind acc_core acc_core_chk #(
  .ADDR_W     (ADDR_W),
  .START_PC   (START_PC),
  .HANDLER_PC (HANDLER_PC)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .memAddr (memAddr),
  .memRdEn (memRdEn),
  .memWrEn (memWrEn),
  .irqAck  (irqAck),
  .intEn   (intEn)
);

// File: tb/acc_core_test.sv
module acc_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] memAddr;
  logic        memRdEn, memWrEn, irqAck;
  logic [15:0] memWrData;
  logic [15:0] memRdData = '0;
  logic        irqReq = 1'b0;

  logic [15:0] mem [0:4095];
  logic        tbWe = 1'b0;
  logic [11:0] tbAddr = '0;
  logic [15:0] tbData = '0;
  logic        cntClr = 1'b0;
  int          wrCount = 0;
  int          ackCount = 0;
  int          nChecks = 0;
  int          nFail = 0;

  always #5 clk = ~clk;

  acc_core uut (
    .clk       (clk),
    .rst       (rst),
    .memAddr   (memAddr),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn),
    .memWrData (memWrData),
    .memRdData (memRdData),
    .irqReq    (irqReq),
    .irqAck    (irqAck)
  );

  // synchronous memory model plus event counters
  always @(posedge clk) begin
    if (tbWe) mem[tbAddr] <= tbData;
    else if (memWrEn) mem[memAddr] <= memWrData;
    if (memRdEn) memRdData <= mem[memAddr];
    if (cntClr) begin
      wrCount  <= 0;
      ackCount <= 0;
    end else begin
      if (memWrEn) wrCount <= wrCount + 1;
      if (irqAck) ackCount <= ackCount + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [15:0] d);
    tbWe = 1'b1; tbAddr = a; tbData = d;
    @(negedge clk);
  endtask

  // hold reset, load words, clear counters; caller then releases reset
  task automatic startLoad();
    @(negedge clk);
    rst = 1'b1;
    cntClr = 1'b1;
  endtask

  task automatic endLoad();
    tbWe = 1'b0;
    @(negedge clk);
    cntClr = 1'b0;
    rst = 1'b0;
  endtask

  // {a, b, a+b mod 2^16}
  localparam logic [47:0] VEC [6] = '{
    {16'h0003, 16'h0004, 16'h0007},
    {16'h1234, 16'h1111, 16'h2345},
    {16'hFFFF, 16'h0001, 16'h0000},
    {16'h8000, 16'h8000, 16'h0000},
    {16'h0000, 16'h0000, 16'h0000},
    {16'h7FFF, 16'h0001, 16'h8000}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin : main
    logic seen;
    repeat (3) @(negedge clk);

    // R1 / R2: reset state and fetch sequencing
    startLoad();
    poke(12'h300, 16'h1940);
    poke(12'h301, 16'h0000);
    poke(12'h940, 16'h0001);
    endLoad();
    check("R1 start addr", 32'(memAddr), 32'h300);
    check("R1 read strobe", 32'(memRdEn), 32'h1);
    check("R1 no write", 32'(memWrEn), 32'h0);
    check("R1 ack low", 32'(irqAck), 32'h0);
    repeat (2) @(negedge clk);
    check("R2 operand read addr", 32'(memAddr), 32'h940);
    repeat (3) @(negedge clk);
    check("R2 next fetch addr", 32'(memAddr), 32'h301);
    repeat (10) @(negedge clk);

    // vector table: load, add, store, halt; R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      startLoad();
      poke(12'h300, 16'h1940);
      poke(12'h301, 16'h5941);
      poke(12'h302, 16'h2941);
      poke(12'h303, 16'h0000);
      poke(12'h304, 16'h2940);
      poke(12'h940, VEC[i][47:32]);
      poke(12'h941, VEC[i][31:16]);
      endLoad();
      repeat (50) @(negedge clk);
      check("R3 R4 R5 sum stored", 32'(mem[12'h941]), 32'(VEC[i][15:0]));
      check("R6 halt blocks later store", 32'(mem[12'h940]), 32'(VEC[i][47:32]));
      check("R5 single write", 32'(wrCount), 32'd1);
    end

    // R1: accumulator cleared by reset (previous run left it nonzero)
    startLoad();
    poke(12'h300, 16'h2942);
    poke(12'h301, 16'h0000);
    poke(12'h942, 16'hABCD);
    endLoad();
    repeat (20) @(negedge clk);
    check("R1 acc cleared", 32'(mem[12'h942]), 32'h0);

    // R7: unused opcode is a no-operation
    startLoad();
    poke(12'h300, 16'h1940);
    poke(12'h301, 16'h7941);
    poke(12'h302, 16'h2942);
    poke(12'h303, 16'h0000);
    poke(12'h940, 16'h0321);
    poke(12'h941, 16'h1000);
    poke(12'h942, 16'h0000);
    endLoad();
    repeat (40) @(negedge clk);
    check("R7 acc unchanged", 32'(mem[12'h942]), 32'h0321);
    check("R7 memory unchanged", 32'(mem[12'h941]), 32'h1000);
    check("R7 writes", 32'(wrCount), 32'd1);

    // R8: request ignored while disabled after reset
    startLoad();
    poke(12'h300, 16'h1940);
    poke(12'h301, 16'h5941);
    poke(12'h302, 16'h2941);
    poke(12'h303, 16'h0000);
    poke(12'h940, 16'h0002);
    poke(12'h941, 16'h0005);
    irqReq = 1'b1;
    endLoad();
    repeat (40) @(negedge clk);
    irqReq = 1'b0;
    check("R8 no ack", 32'(ackCount), 32'd0);
    check("R8 program result", 32'(mem[12'h941]), 32'h0007);

    // R9 R10 R11: enable, take, nested request ignored, return, retake
    startLoad();
    poke(12'h300, 16'hF000);
    poke(12'h301, 16'h1940);
    poke(12'h302, 16'h5941);
    poke(12'h303, 16'h2941);
    poke(12'h304, 16'h0000);
    poke(12'h010, 16'h1950);
    poke(12'h011, 16'h2951);
    poke(12'h012, 16'hF000);
    poke(12'h940, 16'h0003);
    poke(12'h941, 16'h0004);
    poke(12'h950, 16'h5A5A);
    poke(12'h951, 16'h0000);
    irqReq = 1'b1;
    endLoad();
    seen = 1'b0;
    for (int k = 0; k < 30 && !seen; k++) begin
      @(negedge clk);
      seen = irqAck;
    end
    check("R9 ack seen", 32'(seen), 32'h1);
    check("R9 handler fetch", 32'(memAddr), 32'h010);
    irqReq = 1'b0;
    repeat (5) @(negedge clk);
    irqReq = 1'b1;
    repeat (7) @(negedge clk);
    irqReq = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 resume fetch addr", 32'(memAddr), 32'h301);
    check("R10 no nested ack", 32'(ackCount), 32'd1);
    @(negedge clk);
    irqReq = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 30 && !seen; k++) begin
      @(negedge clk);
      seen = irqAck;
    end
    check("R11 re-enabled ack", 32'(seen), 32'h1);
    check("R11 second handler fetch", 32'(memAddr), 32'h010);
    irqReq = 1'b0;
    repeat (80) @(negedge clk);
    check("R9 handler stored", 32'(mem[12'h951]), 32'h5A5A);
    check("R11 resumed after 0x301", 32'(mem[12'h941]), 32'h5A5E);
    check("R10 ack total", 32'(ackCount), 32'd2);
    check("R5 write total", 32'(wrCount), 32'd3);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule